// File: doc/BRIEF.md
# Hart Privilege Mode Tracker with CSR Permission Gate

This block holds the current privilege mode of one hart and the status fields that save and restore it across traps: the previous-mode fields for machine and supervisor level and their interrupt-enable and saved-enable bits. Mode values come from one legalization function. It is set by two parameters that say whether user mode and supervisor mode exist. Every requested mode goes through it: trap targets, supervisor return targets and software writes of the machine previous-mode field.

The block also judges each CSR access. The minimum level a CSR needs sits in its address bits [9:8]. A hart in supervisor mode that is not virtualized counts as level 2 for this check only, so it can reach hypervisor CSRs. Level 2 is never a real mode. Any request for it ends up as user mode. A write to a CSR whose address bits [11:10] are 2'b11 (read-only space) is also rejected. The verdict is a registered illegal-instruction flag.

Top module: `priv_mode_unit`

## Requirements
- R1: Mode encodings are user=2'b00, supervisor=2'b01, machine=2'b11. The current mode never equals 2'b10. After reset the mode is machine, MIE=0, MPIE=0, SPP=0, SIE=0, SPIE=0, and MPP is user, or machine when user mode is absent.
- R2: When user mode is not implemented, the legalization function returns machine for every request.
- R3: With user mode implemented, a request for 2'b10 becomes user. A request for supervisor also becomes user when supervisor mode is absent. Other requests pass unchanged.
- R4: A trap takes the machine path unless its legalized target is supervisor and the current mode is not machine. On the machine path, the next cycle shows MPP equal to the old mode, MPIE equal to the old MIE, MIE=0 and mode machine.
- R5: On the supervisor trap path, the next cycle shows SPP equal to bit 0 of the old mode, SPIE equal to the old SIE, SIE=0 and mode supervisor.
- R6: A machine return sets the mode to MPP, MIE to MPIE and MPIE to 1. It sets MPP to user, or to machine when user mode is absent.
- R7: A supervisor return sets the mode to the legalized value of {1'b0,SPP}, SIE to SPIE, SPIE to 1 and SPP to 0.
- R8: A software status write stores the legalized requested MPP, plus MIE and MPIE. It stores SPP, SIE and SPIE only when supervisor mode exists; otherwise those stay 0.
- R9: One cycle after a CSR access, the illegal flag is 1 when the effective level is below address bits [9:8]. The effective level is 2 in supervisor mode with virtualization off, and the current mode otherwise. The check uses the mode from the access cycle.
- R10: A write access to an address whose bits [11:10] are 2'b11 sets the illegal flag one cycle later, whatever the mode.
- R11: When several events are requested in one cycle, only the highest one acts: trap, then machine return, then supervisor return, then software write. The illegal flag is 0 in the cycle after a cycle with no CSR access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_to | input | 2 | Requested trap target mode |
| mret | input | 1 | Machine return pulse |
| sret | input | 1 | Supervisor return pulse |
| sw_wr | input | 1 | Software write of status fields |
| sw_mpp | input | 2 | Written MPP value (legalized) |
| sw_mie | input | 1 | Written MIE |
| sw_mpie | input | 1 | Written MPIE |
| sw_spp | input | 1 | Written SPP |
| sw_sie | input | 1 | Written SIE |
| sw_spie | input | 1 | Written SPIE |
| csr_valid | input | 1 | CSR access this cycle |
| csr_addr | input | 12 | CSR address |
| csr_write | input | 1 | Access writes the CSR |
| virt | input | 1 | Hart is virtualized |
| cur_mode | output | 2 | Current privilege mode |
| mpp | output | 2 | Machine previous mode |
| spp | output | 1 | Supervisor previous mode |
| mie | output | 1 | Machine interrupt enable |
| mpie | output | 1 | Machine saved interrupt enable |
| sie | output | 1 | Supervisor interrupt enable |
| spie | output | 1 | Supervisor saved interrupt enable |
| illegal | output | 1 | Illegal-instruction flag for the previous access |

## Verification
The hardest case to reach is a non-virtualized supervisor-mode access to a hypervisor CSR. The hart must first drop to user mode through a machine return with MPP at user. It must then take a trap aimed at supervisor, and only then issue the access. The directed prologue walks that path with virtualization off and then on. Random stimulus then mixes traps, returns, status writes (including the reserved value 2) and accesses over all address-level fields. The same stimulus drives copies with supervisor mode or user mode removed, so both legalization branches are checked too.

// File: rtl/priv_pkg.sv
package priv_pkg;
  typedef logic [1:0] prv_t;
  localparam prv_t PRV_U  = 2'b00;
  localparam prv_t PRV_S  = 2'b01;
  localparam prv_t PRV_HS = 2'b10;
  localparam prv_t PRV_M  = 2'b11;
  localparam int CSR_AW      = 12;
  localparam int CSR_LVL_LSB = 8;
  localparam int CSR_RO_LSB  = 10;
endpackage

// File: rtl/priv_legalize.sv
module priv_legalize
  import priv_pkg::*;
#(
  parameter bit HAS_U = 1'b1,
  parameter bit HAS_S = 1'b1
) (
  input  prv_t req,
  output prv_t legal
);
  generate
    if (!HAS_U) begin : g_m_only
      assign legal = PRV_M;
    end else if (!HAS_S) begin : g_mu
      always_comb legal = (req == PRV_S || req == PRV_HS) ? PRV_U : req;
    end else begin : g_msu
      always_comb legal = (req == PRV_HS) ? PRV_U : req;
    end
  endgenerate
endmodule

// File: rtl/priv_status_regs.sv
module priv_status_regs
  import priv_pkg::*;
#(
  parameter bit HAS_U = 1'b1,
  parameter bit HAS_S = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic trap_req,
  input  prv_t trap_tgt,
  input  logic mret,
  input  logic sret,
  input  prv_t sret_tgt,
  input  logic sw_wr,
  input  prv_t sw_mpp_legal,
  input  logic sw_mie,
  input  logic sw_mpie,
  input  logic sw_spp,
  input  logic sw_sie,
  input  logic sw_spie,
  output prv_t mode_q,
  output prv_t mpp_q,
  output logic spp_q,
  output logic mie_q,
  output logic mpie_q,
  output logic sie_q,
  output logic spie_q
);
  localparam prv_t LOW_MODE = HAS_U ? PRV_U : PRV_M;

  logic s_path;
  assign s_path = (trap_tgt == PRV_S) && (mode_q != PRV_M);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PRV_M;
      mpp_q  <= LOW_MODE;
      spp_q  <= 1'b0;
      mie_q  <= 1'b0;
      mpie_q <= 1'b0;
      sie_q  <= 1'b0;
      spie_q <= 1'b0;
    end else if (trap_req) begin
      if (s_path) begin
        spp_q  <= mode_q[0];
        spie_q <= sie_q;
        sie_q  <= 1'b0;
        mode_q <= PRV_S;
      end else begin
        mpp_q  <= mode_q;
        mpie_q <= mie_q;
        mie_q  <= 1'b0;
        mode_q <= PRV_M;
      end
    end else if (mret) begin
      mode_q <= mpp_q;
      mie_q  <= mpie_q;
      mpie_q <= 1'b1;
      mpp_q  <= LOW_MODE;
    end else if (sret) begin
      mode_q <= sret_tgt;
      sie_q  <= spie_q;
      spie_q <= 1'b1;
      spp_q  <= 1'b0;
    end else if (sw_wr) begin
      mpp_q  <= sw_mpp_legal;
      mie_q  <= sw_mie;
      mpie_q <= sw_mpie;
      spp_q  <= HAS_S ? sw_spp  : 1'b0;
      sie_q  <= HAS_S ? sw_sie  : 1'b0;
      spie_q <= HAS_S ? sw_spie : 1'b0;
    end
  end

  a_r1_mode_not_reserved: assert property (@(posedge clk) disable iff (rst)
    mode_q != PRV_HS);
  a_r8_mpp_legal: assert property (@(posedge clk) disable iff (rst)
    (mpp_q != PRV_HS) && (HAS_U || mpp_q == PRV_M));
  a_r4_mtrap_clears_mie: assert property (@(posedge clk) disable iff (rst)
    trap_req && !s_path |=> !mie_q && mode_q == PRV_M);
  a_r5_strap_clears_sie: assert property (@(posedge clk) disable iff (rst)
    trap_req && s_path |=> !sie_q && mode_q == PRV_S);
  a_r6_mret_sets_mpie: assert property (@(posedge clk) disable iff (rst)
    mret && !trap_req |=> mpie_q);
  a_r7_sret_clears_spp: assert property (@(posedge clk) disable iff (rst)
    sret && !trap_req && !mret |=> !spp_q && spie_q);
endmodule

// File: rtl/priv_csr_gate.sv
module priv_csr_gate
  import priv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  prv_t              mode,
  input  logic              virt,
  input  logic              csr_valid,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic              csr_write,
  output logic              illegal_q
);
  prv_t need_lvl, eff_lvl;
  logic ro_space, deny;

  assign need_lvl = csr_addr[CSR_LVL_LSB +: 2];
  assign ro_space = (csr_addr[CSR_RO_LSB +: 2] == 2'b11);
  assign eff_lvl  = (mode == PRV_S && !virt) ? PRV_HS : mode;
  assign deny     = (eff_lvl < need_lvl) || (csr_write && ro_space);

  always_ff @(posedge clk) begin
    if (rst) illegal_q <= 1'b0;
    else     illegal_q <= csr_valid && deny;
  end

  a_r11_illegal_needs_access: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> $past(csr_valid));
  a_r9_m_read_allowed: assert property (@(posedge clk) disable iff (rst)
    csr_valid && mode == PRV_M && !csr_write |=> !illegal_q);
  a_r10_ro_write_denied: assert property (@(posedge clk) disable iff (rst)
    csr_valid && csr_write && ro_space |=> illegal_q);
endmodule

// File: rtl/priv_mode_unit.sv
module priv_mode_unit
  import priv_pkg::*;
#(
  parameter bit HAS_U = 1'b1,
  parameter bit HAS_S = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        trap_req,
  input  logic [1:0]  trap_to,
  input  logic        mret,
  input  logic        sret,
  input  logic        sw_wr,
  input  logic [1:0]  sw_mpp,
  input  logic        sw_mie,
  input  logic        sw_mpie,
  input  logic        sw_spp,
  input  logic        sw_sie,
  input  logic        sw_spie,
  input  logic        csr_valid,
  input  logic [11:0] csr_addr,
  input  logic        csr_write,
  input  logic        virt,
  output logic [1:0]  cur_mode,
  output logic [1:0]  mpp,
  output logic        spp,
  output logic        mie,
  output logic        mpie,
  output logic        sie,
  output logic        spie,
  output logic        illegal
);
  prv_t trap_tgt, sret_tgt, mpp_legal, mode_w;

  priv_legalize #(.HAS_U(HAS_U), .HAS_S(HAS_S)) u_leg_trap (
    .req(trap_to), .legal(trap_tgt));
  priv_legalize #(.HAS_U(HAS_U), .HAS_S(HAS_S)) u_leg_sret (
    .req({1'b0, spp}), .legal(sret_tgt));
  priv_legalize #(.HAS_U(HAS_U), .HAS_S(HAS_S)) u_leg_sw (
    .req(sw_mpp), .legal(mpp_legal));

  priv_status_regs #(.HAS_U(HAS_U), .HAS_S(HAS_S)) u_regs (
    .clk(clk), .rst(rst),
    .trap_req(trap_req), .trap_tgt(trap_tgt),
    .mret(mret), .sret(sret), .sret_tgt(sret_tgt),
    .sw_wr(sw_wr), .sw_mpp_legal(mpp_legal),
    .sw_mie(sw_mie), .sw_mpie(sw_mpie), .sw_spp(sw_spp),
    .sw_sie(sw_sie), .sw_spie(sw_spie),
    .mode_q(mode_w), .mpp_q(mpp), .spp_q(spp),
    .mie_q(mie), .mpie_q(mpie), .sie_q(sie), .spie_q(spie));

  priv_csr_gate u_gate (
    .clk(clk), .rst(rst), .mode(mode_w), .virt(virt),
    .csr_valid(csr_valid), .csr_addr(csr_addr), .csr_write(csr_write),
    .illegal_q(illegal));

  assign cur_mode = mode_w;

  a_r2_no_user_stays_m: assert property (@(posedge clk) disable iff (rst)
    !HAS_U |-> cur_mode == PRV_M);
  a_r3_no_super_never_s: assert property (@(posedge clk) disable iff (rst)
    !HAS_S |-> cur_mode != PRV_S);
endmodule

// File: tb/sim_priv_mode_unit.sv
`timescale 1ns/1ps
module sim_priv_mode_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic trap_req = 0, mret = 0, sret = 0, sw_wr = 0;
  logic [1:0] trap_to = 0, sw_mpp = 0;
  logic sw_mie = 0, sw_mpie = 0, sw_spp = 0, sw_sie = 0, sw_spie = 0;
  logic csr_valid = 0, csr_write = 0, virt = 0;
  logic [11:0] csr_addr = 0;

  logic [9:0] obs [3];
  logic [1:0] o_mode [3], o_mpp [3];
  logic o_spp [3], o_mie [3], o_mpie [3], o_sie [3], o_spie [3], o_ill [3];

  priv_mode_unit #(.HAS_U(1'b1), .HAS_S(1'b1)) u0 (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_to(trap_to), .mret(mret), .sret(sret),
    .sw_wr(sw_wr), .sw_mpp(sw_mpp), .sw_mie(sw_mie), .sw_mpie(sw_mpie), .sw_spp(sw_spp),
    .sw_sie(sw_sie), .sw_spie(sw_spie), .csr_valid(csr_valid), .csr_addr(csr_addr),
    .csr_write(csr_write), .virt(virt), .cur_mode(o_mode[0]), .mpp(o_mpp[0]), .spp(o_spp[0]),
    .mie(o_mie[0]), .mpie(o_mpie[0]), .sie(o_sie[0]), .spie(o_spie[0]), .illegal(o_ill[0]));
  priv_mode_unit #(.HAS_U(1'b1), .HAS_S(1'b0)) u1 (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_to(trap_to), .mret(mret), .sret(sret),
    .sw_wr(sw_wr), .sw_mpp(sw_mpp), .sw_mie(sw_mie), .sw_mpie(sw_mpie), .sw_spp(sw_spp),
    .sw_sie(sw_sie), .sw_spie(sw_spie), .csr_valid(csr_valid), .csr_addr(csr_addr),
    .csr_write(csr_write), .virt(virt), .cur_mode(o_mode[1]), .mpp(o_mpp[1]), .spp(o_spp[1]),
    .mie(o_mie[1]), .mpie(o_mpie[1]), .sie(o_sie[1]), .spie(o_spie[1]), .illegal(o_ill[1]));
  priv_mode_unit #(.HAS_U(1'b0), .HAS_S(1'b1)) u2 (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_to(trap_to), .mret(mret), .sret(sret),
    .sw_wr(sw_wr), .sw_mpp(sw_mpp), .sw_mie(sw_mie), .sw_mpie(sw_mpie), .sw_spp(sw_spp),
    .sw_sie(sw_sie), .sw_spie(sw_spie), .csr_valid(csr_valid), .csr_addr(csr_addr),
    .csr_write(csr_write), .virt(virt), .cur_mode(o_mode[2]), .mpp(o_mpp[2]), .spp(o_spp[2]),
    .mie(o_mie[2]), .mpie(o_mpie[2]), .sie(o_sie[2]), .spie(o_spie[2]), .illegal(o_ill[2]));

  always_comb
    for (int k = 0; k < 3; k++)
      obs[k] = {o_mode[k], o_mpp[k], o_spp[k], o_mie[k], o_mpie[k], o_sie[k], o_spie[k], o_ill[k]};

  // reference model
  bit hu [3] = '{1'b1, 1'b1, 1'b0};
  bit hs [3] = '{1'b1, 1'b0, 1'b1};
  logic [1:0] m_mode [3], m_mpp [3];
  logic m_spp [3], m_mie [3], m_mpie [3], m_sie [3], m_spie [3], m_ill [3];

  int checks = 0, errors = 0;

  function automatic logic [1:0] leg(input logic [1:0] p, input bit u, input bit s);
    if (!u) return 2'b11;                       // R2
    if (p == 2'b10 || (p == 2'b01 && !s)) return 2'b00;  // R3
    return p;
  endfunction

  function automatic logic [9:0] expv(input int k);
    return {m_mode[k], m_mpp[k], m_spp[k], m_mie[k], m_mpie[k], m_sie[k], m_spie[k], m_ill[k]};
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin
      m_mode[k] = 2'b11; m_mpp[k] = hu[k] ? 2'b00 : 2'b11;
      m_spp[k] = 0; m_mie[k] = 0; m_mpie[k] = 0; m_sie[k] = 0; m_spie[k] = 0; m_ill[k] = 0;
    end
  endtask

  task automatic model_step();
    for (int k = 0; k < 3; k++) begin
      logic [1:0] eff, t;
      eff = (m_mode[k] == 2'b01 && !virt) ? 2'b10 : m_mode[k];
      m_ill[k] = csr_valid && ((eff < csr_addr[9:8]) || (csr_write && csr_addr[11:10] == 2'b11));
      if (trap_req) begin
        t = leg(trap_to, hu[k], hs[k]);
        if (t == 2'b01 && m_mode[k] != 2'b11) begin
          m_spp[k] = m_mode[k][0]; m_spie[k] = m_sie[k]; m_sie[k] = 0; m_mode[k] = 2'b01;
        end else begin
          m_mpp[k] = m_mode[k]; m_mpie[k] = m_mie[k]; m_mie[k] = 0; m_mode[k] = 2'b11;
        end
      end else if (mret) begin
        m_mode[k] = m_mpp[k]; m_mie[k] = m_mpie[k]; m_mpie[k] = 1;
        m_mpp[k] = hu[k] ? 2'b00 : 2'b11;
      end else if (sret) begin
        m_mode[k] = leg({1'b0, m_spp[k]}, hu[k], hs[k]);
        m_sie[k] = m_spie[k]; m_spie[k] = 1; m_spp[k] = 0;
      end else if (sw_wr) begin
        m_mpp[k] = leg(sw_mpp, hu[k], hs[k]); m_mie[k] = sw_mie; m_mpie[k] = sw_mpie;
        m_spp[k] = hs[k] ? sw_spp : 0; m_sie[k] = hs[k] ? sw_sie : 0;
        m_spie[k] = hs[k] ? sw_spie : 0;
      end
    end
  endtask

  task automatic compare(input string tag);
    for (int k = 0; k < 3; k++) begin
      checks++;
      if (obs[k] !== expv(k)) begin
        errors++;
        $display("FAIL %s dut%0d: got %b expected %b", tag, k, obs[k], expv(k));
      end
    end
  endtask

  task automatic clear_in();
    trap_req = 0; mret = 0; sret = 0; sw_wr = 0; csr_valid = 0; csr_write = 0;
  endtask

  // inputs already set at a negedge; clock once, then compare at next negedge
  task automatic step(input string tag);
    model_step();
    @(negedge clk);
    clear_in();
    compare(tag);
  endtask

  task automatic csr(input logic [11:0] a, input logic w, input logic v, input string tag);
    csr_valid = 1; csr_addr = a; csr_write = w; virt = v;
    step(tag);
  endtask

  function automatic string tag_of();
    if (trap_req) return "R4/R5 trap R11";
    if (mret) return "R6 mret R11";
    if (sret) return "R7 sret R11";
    if (sw_wr) return "R8 swwrite R2 R3";
    if (csr_valid) return "R9 R10 access";
    return "R11 idle";
  endfunction

  bit done = 0;
  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    compare("R1 reset");

    // R3: reserved value written to MPP becomes user
    sw_wr = 1; sw_mpp = 2'b10; sw_mie = 1; sw_mpie = 1; sw_spp = 1; sw_sie = 1; sw_spie = 0;
    step("R3 R8 mpp=2");
    mret = 1; step("R6 mret to legal mpp");
    trap_req = 1; trap_to = 2'b01; step("R5 trap to S from U");
    csr(12'h600, 1'b0, 1'b0, "R9 S non-virt reaches level 2");
    csr(12'h600, 1'b0, 1'b1, "R9 S virt denied level 2");
    csr(12'h300, 1'b0, 1'b0, "R9 S denied machine CSR");
    csr(12'hC00, 1'b1, 1'b0, "R10 write read-only");
    csr(12'hC00, 1'b0, 1'b0, "R10 read of read-only ok");
    sret = 1; step("R7 sret to U");
    trap_req = 1; trap_to = 2'b10; step("R3 R4 trap to level 2");
    trap_req = 1; trap_to = 2'b01; step("R4 S target from M stays M");
    trap_req = 1; mret = 1; sret = 1; sw_wr = 1; sw_mpp = 2'b01; trap_to = 2'b11;
    step("R11 priority");
    @(negedge clk); compare("R11 idle no illegal");

    for (int i = 0; i < 4000; i++) begin
      int r;
      string tg;
      r = $urandom_range(0, 15);
      trap_req = (r == 0) || (r == 1);
      trap_to  = 2'($urandom_range(0, 3));
      mret     = (r == 2) || (r == 3) || (r == 15);
      sret     = (r == 4) || (r == 5) || (r == 15);
      sw_wr    = (r == 6) || (r == 7);
      sw_mpp   = 2'($urandom_range(0, 3));
      {sw_mie, sw_mpie, sw_spp, sw_sie, sw_spie} = 5'($urandom_range(0, 31));
      csr_valid = ($urandom_range(0, 1) == 1);
      csr_addr  = 12'($urandom_range(0, 4095));
      csr_write = ($urandom_range(0, 1) == 1);
      virt      = ($urandom_range(0, 3) == 0);
      tg = tag_of();
      step(tg);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule